// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the integer register file of a small 32-bit RISC core in which the set of visible registers depends on the processor mode. Sixteen architectural registers are addressed with 4-bit numbers. The first fifteen are held in storage. The last one carries the program counter, which comes from outside the block. A 5-bit mode input picks which physical copy stands behind each architectural number. Two combinational read ports and one clocked write port all use that mapping.

The fast-interrupt mode has its own private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each have private copies of only the stack pointer (13) and the link register (14). All other registers are shared with user mode. User and system modes see the same registers. Each of the five exception modes also has its own saved-status word, which is reached through a separate read and write port. The exception sequencing logic uses these words to save and restore status.

Top module: `bnk_regfile`

## Requirements
- R1: Reset (rst_n low) clears every physical register and every saved-status word to zero.
- R2: The mode codes are user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code behaves exactly as user.
- R3: Registers 0 to 7 are one shared set in every mode. A write in any mode is seen by a read in any other mode.
- R4: In fast-interrupt mode, registers 8 to 14 select seven private copies. Writes made there are not seen from any other mode, and writes made from other modes are not seen there.
- R5: In normal-interrupt, supervisor, abort and undefined mode, registers 13 and 14 are private to each of those modes. Registers 8 to 12 are shared with user mode.
- R6: System mode and user mode address the same physical registers.
- R7: A read of register 15 returns pc_i on either port. A write to register 15 changes no stored register.
- R8: A write goes to the copy selected by the mode present at that clock edge. The data appears on the read ports from the following cycle. A read of the same register in the cycle of the write returns the old value.
- R9: The two read ports are independent, and each returns its own register within the same cycle.
- R10: Each exception mode has its own saved-status word. ssr_rd_data shows the word of the current mode, and a write with ssr_wr_en updates it at the clock edge.
- R11: In user or system mode (and in any mode code treated as user), ssr_rd_data reads zero and saved-status writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| pc_i | input | 32 | Program counter value returned for register 15 |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| ssr_wr_en | input | 1 | Saved-status write enable |
| ssr_wr_data | input | 32 | Saved-status write data |
| ssr_rd_data | output | 32 | Saved-status word of the current mode |

## Verification
A mapping fault stores a write in the wrong physical copy. It stays hidden until some later read goes through a mode whose view differs from the writer's. The bench therefore switches mode on almost every cycle and compares both read ports against a per-mode view model on every cycle. A bad bank then shows up on the first cross-mode read of that register, normally within a few dozen cycles. A corrupted saved-status slot shows on ssr_rd_data the next time its mode is selected.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

    // Mode codes on the mode input
    localparam logic [4:0] MC_USR = 5'b10000;
    localparam logic [4:0] MC_FIQ = 5'b10001;
    localparam logic [4:0] MC_IRQ = 5'b10010;
    localparam logic [4:0] MC_SVC = 5'b10011;
    localparam logic [4:0] MC_ABT = 5'b10111;
    localparam logic [4:0] MC_UND = 5'b11011;
    localparam logic [4:0] MC_SYS = 5'b11111;

    // Bank class: user view first, then one class per exception mode
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int unsigned NUM_EXC   = 5;
    localparam int unsigned ARCH_W    = 4;
    localparam int unsigned NUM_SHARE = 15;  // user-view copies of r0..r14
    localparam int unsigned FIQ_LO    = 8;   // first register banked in FIQ
    localparam int unsigned SP_IDX    = 13;
    localparam int unsigned PC_IDX    = 15;
    localparam int unsigned FIQ_CNT   = SP_IDX - FIQ_LO;             // r8..r12 copies
    localparam int unsigned PAIR_BASE = NUM_SHARE + FIQ_CNT;         // first sp/lr pair
    localparam int unsigned NUM_PHYS  = PAIR_BASE + 2 * NUM_EXC;     // 30
    localparam int unsigned PHYS_W    = $clog2(NUM_PHYS);

endpackage

// File: rtl/bnk_mode_dec.sv
module bnk_mode_dec
    import bnk_pkg::*;
(
    input  logic [4:0] mode_i,
    output bank_e      bank_o,
    output logic       has_ssr_o
);

    always_comb begin
        unique case (mode_i)
            MC_FIQ:  bank_o = BK_FIQ;
            MC_IRQ:  bank_o = BK_IRQ;
            MC_SVC:  bank_o = BK_SVC;
            MC_ABT:  bank_o = BK_ABT;
            MC_UND:  bank_o = BK_UND;
            default: bank_o = BK_USR;  // user, system and unknown codes
        endcase
        has_ssr_o = (bank_o != BK_USR);
    end

endmodule

// File: rtl/bnk_phys_map.sv
module bnk_phys_map
    import bnk_pkg::*;
(
    input  logic [ARCH_W-1:0] arch_i,
    input  bank_e             bank_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              is_pc_o
);

    logic [PHYS_W-1:0] arch_ext;
    logic [PHYS_W-1:0] bank_ext;

    assign arch_ext = PHYS_W'(arch_i);
    assign bank_ext = PHYS_W'(bank_i);

    always_comb begin
        is_pc_o = (arch_i == ARCH_W'(PC_IDX));
        phys_o  = arch_ext;
        if (arch_i >= ARCH_W'(SP_IDX) && !is_pc_o) begin
            if (bank_i != BK_USR) begin
                phys_o = PHYS_W'(PAIR_BASE) + ((bank_ext - PHYS_W'(1)) << 1)
                       + (arch_ext - PHYS_W'(SP_IDX));
            end
        end else if (arch_i >= ARCH_W'(FIQ_LO) && bank_i == BK_FIQ) begin
            phys_o = PHYS_W'(NUM_SHARE) + (arch_ext - PHYS_W'(FIQ_LO));
        end
    end

endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile
    import bnk_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RD_PORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ssr_wr_en,
    input  logic [DATA_W-1:0] ssr_wr_data,
    output logic [DATA_W-1:0] ssr_rd_data
);

    localparam int unsigned SLOT_W = $clog2(NUM_EXC);

    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] gpr;
        logic [NUM_EXC-1:0][DATA_W-1:0]  ssr;
    } rf_state_t;

    rf_state_t st_d, st_q;

    bank_e bank;
    logic  has_ssr;

    bnk_mode_dec u_dec (
        .mode_i    (mode_i),
        .bank_o    (bank),
        .has_ssr_o (has_ssr)
    );

    // Read ports
    logic [RD_PORTS-1:0][ARCH_W-1:0] rd_idx;
    logic [RD_PORTS-1:0][DATA_W-1:0] rd_val;

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [PHYS_W-1:0] phys;
        logic              is_pc;

        bnk_phys_map u_map (
            .arch_i  (rd_idx[p]),
            .bank_i  (bank),
            .phys_o  (phys),
            .is_pc_o (is_pc)
        );

        assign rd_val[p] = is_pc ? pc_i : st_q.gpr[phys];
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];

    // Write port
    logic [PHYS_W-1:0] wr_phys;
    logic              wr_is_pc;

    bnk_phys_map u_wmap (
        .arch_i  (wr_idx),
        .bank_i  (bank),
        .phys_o  (wr_phys),
        .is_pc_o (wr_is_pc)
    );

    logic [SLOT_W-1:0] ssr_slot;
    assign ssr_slot = SLOT_W'(bank) - SLOT_W'(1);

    assign ssr_rd_data = has_ssr ? st_q.ssr[ssr_slot] : '0;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_is_pc) begin
            st_d.gpr[wr_phys] = wr_data;
        end
        if (ssr_wr_en && has_ssr) begin
            st_d.ssr[ssr_slot] = ssr_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mode_i,
    input logic [31:0] pc_i,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_idx,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        ssr_wr_en,
    input logic [31:0] ssr_wr_data,
    input logic [31:0] ssr_rd_data
);

    logic exc_mode;
    assign exc_mode = (mode_i == 5'b10001) || (mode_i == 5'b10010) || (mode_i == 5'b10011)
                   || (mode_i == 5'b10111) || (mode_i == 5'b11011);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && rd_a_idx != 4'd15) |-> rd_a_data == 32'd0);

    assert_pc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 4'd15) |-> rd_b_data == pc_i);

    assert_write_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 4'd15
         && rd_a_idx == $past(wr_idx) && mode_i == $past(mode_i))
        |-> rd_a_data == $past(wr_data));

    assert_ssr_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ssr_wr_en) && $past(exc_mode) && mode_i == $past(mode_i))
        |-> ssr_rd_data == $past(ssr_wr_data));

    assert_ssr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> ssr_rd_data == 32'd0);

endmodule

bind bnk_regfile bnk_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .pc_i        (pc_i),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .ssr_wr_en   (ssr_wr_en),
    .ssr_wr_data (ssr_wr_data),
    .ssr_rd_data (ssr_rd_data)
);

// File: tb/sim_bnk_regfile.sv
module sim_bnk_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic [31:0] pc_i = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, ssr_rd_data;
    logic        wr_en = 1'b0, ssr_wr_en = 1'b0;
    logic [31:0] wr_data = '0, ssr_wr_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Per-view model: view 0 user/system, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    logic [31:0] view [6][15];
    logic [31:0] sav  [6];

    always #10 clk = ~clk;  // 50 MHz

    bnk_regfile u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pc_i(pc_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ssr_wr_en(ssr_wr_en), .ssr_wr_data(ssr_wr_data), .ssr_rd_data(ssr_rd_data)
    );

    function automatic int view_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    // Do views a and b reach the same copy of register r?
    function automatic bit shared(int a, int b, int r);
        if (r < 8)  return 1'b1;
        if (r < 13) return (a == 1) == (b == 1);
        return a == b;
    endfunction

    function automatic logic [31:0] expect_rd(logic [4:0] m, logic [3:0] r);
        if (r == 4'd15) return pc_i;
        return view[view_of(m)][r];
    endfunction

    function automatic logic [31:0] expect_ssr(logic [4:0] m);
        return sav[view_of(m)];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (mode %b)", req, act, exp, mode_i);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 6; v++) begin
            sav[v] = '0;
            for (int r = 0; r < 15; r++) view[v][r] = '0;
        end
    endtask

    // Apply inputs at negedge, check reads before edge, update model at edge
    task automatic cycle(string req, logic [4:0] m, logic [3:0] ra, logic [3:0] rb,
                         logic we, logic [3:0] wi, logic [31:0] wd,
                         logic se, logic [31:0] sd);
        @(negedge clk);
        mode_i = m; rd_a_idx = ra; rd_b_idx = rb;
        wr_en = we; wr_idx = wi; wr_data = wd;
        ssr_wr_en = se; ssr_wr_data = sd;
        pc_i = $urandom;
        #2;
        check(req, rd_a_data, expect_rd(m, ra));
        check({req, "/R9"}, rd_b_data, expect_rd(m, rb));
        check({req, "/R10"}, ssr_rd_data, expect_ssr(m));
        @(posedge clk);
        if (we && wi != 4'd15) begin
            for (int v = 0; v < 6; v++)
                if (shared(view_of(m), v, int'(wi))) view[v][wi] = wd;
        end
        if (se && view_of(m) != 0) sav[view_of(m)] = sd;
    endtask

    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00110};

    initial begin : watchdog
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // dirty the state while in reset; must stay zero (R1)
        repeat (3) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hFFFF_FFFF; ssr_wr_en = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0; ssr_wr_en = 1'b0;
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        for (int r = 0; r < 15; r++)
            cycle("R1", modes[r % 6], 4'(r), 4'(14 - r), 0, 0, 0, 0, 0);
        cycle("R1", 5'b10011, 4'd13, 4'd14, 0, 0, 0, 0, 0);

        // R3: low register shared across modes
        cycle("R3", 5'b10001, 4'd5, 4'd0, 1, 4'd5, 32'hA5A5_0005, 0, 0);
        cycle("R3", 5'b10000, 4'd5, 4'd5, 0, 0, 0, 0, 0);
        cycle("R3", 5'b11011, 4'd5, 4'd5, 0, 0, 0, 0, 0);
        // R4: FIQ private r8..r14
        cycle("R4", 5'b10001, 4'd10, 4'd14, 1, 4'd10, 32'hF1F1_000A, 0, 0);
        cycle("R4", 5'b10000, 4'd10, 4'd10, 1, 4'd10, 32'h0505_000A, 0, 0);
        cycle("R4", 5'b10001, 4'd10, 4'd8, 0, 0, 0, 0, 0);
        cycle("R4", 5'b10000, 4'd10, 4'd10, 0, 0, 0, 0, 0);
        // R5: IRQ banks only sp/lr
        cycle("R5", 5'b10010, 4'd13, 4'd12, 1, 4'd13, 32'h1111_0013, 0, 0);
        cycle("R5", 5'b10010, 4'd12, 4'd13, 1, 4'd12, 32'h1111_0012, 0, 0);
        cycle("R5", 5'b10000, 4'd12, 4'd13, 0, 0, 0, 0, 0);
        cycle("R5", 5'b10011, 4'd13, 4'd12, 1, 4'd14, 32'h3333_0014, 0, 0);
        cycle("R5", 5'b10111, 4'd14, 4'd13, 0, 0, 0, 0, 0);
        cycle("R5", 5'b10011, 4'd14, 4'd13, 0, 0, 0, 0, 0);
        // R6: system and user same set
        cycle("R6", 5'b11111, 4'd13, 4'd9, 1, 4'd13, 32'h5555_5555, 0, 0);
        cycle("R6", 5'b10000, 4'd13, 4'd9, 0, 0, 0, 0, 0);
        // R2: unknown code behaves as user
        cycle("R2", 5'b00000, 4'd14, 4'd11, 1, 4'd14, 32'h2222_0E0E, 0, 0);
        cycle("R2", 5'b10000, 4'd14, 4'd11, 0, 0, 0, 0, 0);
        cycle("R2", 5'b10001, 4'd14, 4'd11, 0, 0, 0, 0, 0);
        // R7: r15 is pc_i; writes ignored
        cycle("R7", 5'b10000, 4'd15, 4'd15, 1, 4'd15, 32'hDEAD_BEEF, 0, 0);
        cycle("R7", 5'b10001, 4'd15, 4'd14, 0, 0, 0, 0, 0);
        // R8: same-cycle read returns old value, new value next cycle
        cycle("R8", 5'b10011, 4'd2, 4'd2, 1, 4'd2, 32'h8888_0002, 0, 0);
        cycle("R8", 5'b10011, 4'd2, 4'd2, 0, 0, 0, 0, 0);
        // R10 / R11: saved-status words
        cycle("R10", 5'b10010, 4'd0, 4'd1, 0, 0, 0, 1, 32'h0000_00D2);
        cycle("R10", 5'b10111, 4'd0, 4'd1, 0, 0, 0, 1, 32'h0000_00D7);
        cycle("R10", 5'b10010, 4'd0, 4'd1, 0, 0, 0, 0, 0);
        cycle("R11", 5'b10000, 4'd0, 4'd1, 0, 0, 0, 1, 32'hBAD0_0000);
        cycle("R11", 5'b11111, 4'd0, 4'd1, 0, 0, 0, 1, 32'hBAD0_0001);
        cycle("R11", 5'b10111, 4'd0, 4'd1, 0, 0, 0, 0, 0);
        cycle("R11", 5'b10000, 4'd0, 4'd1, 0, 0, 0, 0, 0);

        // Constrained random mix (R3, R4, R5, R8, R9)
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] m;
            logic [3:0] ra, rb, wi;
            m  = modes[$urandom_range(7)];
            ra = 4'($urandom_range(15));
            rb = ($urandom_range(3) == 0) ? ra : 4'($urandom_range(15));
            wi = ($urandom_range(1) == 0) ? 4'(8 + $urandom_range(7)) : 4'($urandom_range(15));
            cycle("R9", m, ra, rb, ($urandom_range(2) != 0), wi, $urandom,
                  ($urandom_range(3) == 0), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule